// File: doc/BRIEF.md
# Flux-Stream Write Serializer (MMFM/FM) with CRC-16

This block converts bytes into a stream of flux transitions for a floppy write path. It handles one data byte and one clock byte per byte period of eight bit cells. Each bit cell is sent as two half cells: the clock half goes out first and the data half second. A half-cell enable tick (`half_tick`) sets the pace. The block emits a one-clock pulse on `flux` for each half cell that carries a transition.

There are two encodings:
- **High-density mode.** Bits leave least-significant first. The stream uses modified-modified FM, so the data is delayed by two cells and every clock bit is recomputed from the delayed data and from whether the previous cell had a transition.
- **Low-density mode.** Bits leave most-significant first. The stream is plain FM, and the clock and data bits pass unchanged.

A CRC-16 generator sits in the data path. It either accumulates over the outgoing data bits or replaces them with its own register, so the check word can be appended to a record.

Software loads a byte pair with `byte_wr` before a byte boundary. If no pair is waiting, the shift registers keep running with their fill pattern. `wr_gate` passes the stream to the drive only when write-to-drive is enabled. Otherwise the stream serves only as a loopback source.

Top module: `wser_top`

## Requirements
- R1: In low-density mode (`hd_mode`=0), each cell emits the clock half, then the data half, one per `half_tick`. The bits come from the most significant bit downward and pass unchanged (plain FM). Data A5h with clock C7h gives the half-cell sequence 11 10 01 00 00 11 10 11.
- R2: In high-density mode (`hd_mode`=1), bits leave least significant first. The emitted data half equals the data bit from two cells earlier. The emitted clock half is 1 only when that delayed data bit is 0 and either the clock-register bit is 1 or the previous cell had no transition.
- R3: A byte period is 8 cells (16 half ticks), counted from the first tick after `wr_on` rises. A pair written with `byte_wr` before a period starts is shifted out in that period. Otherwise the period repeats the fill: data all 1s and clock all 0s (low-density half cells 01 repeated).
- R4: With `crc_on`=1 and `crc_out`=0, every outgoing data bit (before the high-density delay) updates a CRC-16. The CRC uses polynomial 1021h, is preset to FFFFh and is processed most significant bit first. The ASCII string "123456789" yields 29B1h.
- R5: With `crc_out`=1, every data bit is replaced by CRC bit 15 and the CRC shifts left by one, so two byte periods emit the CRC word most significant bit first.
- R6: With `crc_on`=0 and `crc_out`=0, the CRC is held at FFFFh, so a following `crc_out` period emits sixteen 1 data bits.
- R7: While both `wr_on` and `rd_on` are 0, the CRC is preset to FFFFh and the CRC controls are ignored. While `rd_on`=1 and `wr_on`=0, the CRC keeps its value.
- R8: While `wr_on`=0, no flux pulse is emitted and the cell count restarts. A rise of `wr_on` clears the high-density history and the previous-transition flag.
- R9: `flux` is high for exactly the clock cycle after a `half_tick` cycle whose half cell carries a transition, and is low in every other cycle.
- R10: `wr_gate` is 1 exactly when `wr_on` and `drive_en` are both 1. It is 0 out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_tick | input | 1 | One-cycle enable per half bit cell |
| hd_mode | input | 1 | 1 = high-density MMFM, 0 = low-density FM |
| wr_on | input | 1 | Write path enable |
| rd_on | input | 1 | Read path enable (keeps the CRC alive) |
| crc_on | input | 1 | Accumulate CRC over data bits |
| crc_out | input | 1 | Replace data bits with CRC bits |
| drive_en | input | 1 | Route the stream to the drive |
| byte_wr | input | 1 | Load strobe for the next byte pair |
| data_in | input | DATA_W | Next data byte |
| clock_in | input | DATA_W | Next clock byte |
| flux | output | 1 | One-cycle pulse per half cell with a transition |
| wr_gate | output | 1 | Write gate to the drive |

## Verification
A stale history bit or a missed clear of the transition flag in high-density mode appears within the first two cells after `wr_on` rises, as a wrong clock half. For that reason the bench checks a literal pattern right after a restart. A CRC register that is off by one bit stays hidden while it only accumulates. It shows up only in the sixteen data halves of the following `crc_out` periods, so the bench compares those halves against a known check word. A shift register that loses its fill or its pending byte corrupts the very next byte period, and the bench sees that directly in the half-cell sequence.

// File: rtl/wser_pkg.sv
package wser_pkg;
  localparam int CRC_W = 16;
  typedef logic [CRC_W-1:0] crc_t;
  typedef enum logic {HALF_CLK = 1'b0, HALF_DAT = 1'b1} half_e;

  // One serial CRC step, MSB first
  function automatic crc_t crc_feed(crc_t cur, logic bit_in, crc_t poly);
    crc_t sh;
    sh = {cur[CRC_W-2:0], 1'b0};
    return (cur[CRC_W-1] ^ bit_in) ? (sh ^ poly) : sh;
  endfunction

  // MMFM clock rule: no clock next to a data transition or after a busy cell
  function automatic logic mmfm_clock(logic dly_data, logic clk_bit, logic had_flux);
    return !dly_data && (clk_bit || !had_flux);
  endfunction
endpackage

// File: rtl/wser_shift.sv
module wser_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hd,
  input  logic         byte_wr,
  input  logic [W-1:0] data_in,
  input  logic [W-1:0] clock_in,
  input  logic         take,
  input  logic         first,
  output logic         raw_d,
  output logic         raw_c
);
  logic [W-1:0] sr_d, sr_c, hold_d, hold_c, src_d, src_c;
  logic         pend_q;
  logic         use_hold;

  assign use_hold = first && pend_q;

  always_comb begin
    src_d = use_hold ? hold_d : sr_d;
    src_c = use_hold ? hold_c : sr_c;
    raw_d = hd ? src_d[0] : src_d[W-1];
    raw_c = hd ? src_c[0] : src_c[W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_d   <= '1;
      sr_c   <= '0;
      hold_d <= '0;
      hold_c <= '0;
      pend_q <= 1'b0;
    end else begin
      if (byte_wr) begin
        hold_d <= data_in;
        hold_c <= clock_in;
      end
      if (take) begin
        // data refills with ones, clock with zeros
        sr_d <= hd ? {1'b1, src_d[W-1:1]} : {src_d[W-2:0], 1'b1};
        sr_c <= hd ? {1'b0, src_c[W-1:1]} : {src_c[W-2:0], 1'b0};
      end
      if (byte_wr)               pend_q <= 1'b1;
      else if (take && use_hold) pend_q <= 1'b0;
    end
  end

  assert_pend_consumed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && use_hold && !byte_wr) |=> !pend_q);
  assert_pend_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_wr |=> pend_q);
endmodule

// File: rtl/wser_crc.sv
module wser_crc
  import wser_pkg::*;
#(
  parameter crc_t POLY   = 16'h1021,
  parameter crc_t PRESET = 16'hFFFF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic crc_on,
  input  logic crc_out,
  input  logic step,
  input  logic raw_bit,
  output logic out_bit
);
  crc_t crc_q;
  logic acc_en, emit_en;

  assign acc_en  = crc_on  && active;
  assign emit_en = crc_out && active;
  assign out_bit = emit_en ? crc_q[CRC_W-1] : raw_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   crc_q <= PRESET;
    else if (!acc_en && !emit_en) crc_q <= PRESET;
    else if (step) begin
      if (emit_en) crc_q <= {crc_q[CRC_W-2:0], 1'b0};
      else         crc_q <= crc_feed(crc_q, raw_bit, POLY);
    end
  end

  assert_preset_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> crc_q == PRESET);
  assert_hold_preset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !crc_on && !crc_out) |=> crc_q == PRESET);
  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !step) |=> $stable(crc_q) || crc_q == PRESET);
endmodule

// File: rtl/wser_enc.sv
module wser_enc
  import wser_pkg::*;
#(
  parameter int DELAY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  input  logic hd,
  input  logic d_in,
  input  logic c_in,
  output logic enc_c,
  output logic enc_d
);
  logic [DELAY-1:0] hist_q;
  logic             had_q;
  logic             dly;

  assign dly   = hist_q[DELAY-1];
  assign enc_d = hd ? dly : d_in;
  assign enc_c = hd ? mmfm_clock(dly, c_in, had_q) : c_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      had_q  <= 1'b0;
    end else if (clear) begin
      hist_q <= '0;
      had_q  <= 1'b0;
    end else if (step) begin
      hist_q <= {hist_q[DELAY-2:0], d_in};
      had_q  <= enc_c || enc_d;
    end
  end

  assert_clear_history_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (hist_q == '0 && !had_q));
  assert_history_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear) |=> hist_q[0] == $past(d_in));
endmodule

// File: rtl/wser_top.sv
module wser_top
  import wser_pkg::*;
#(
  parameter int   DATA_W     = 8,
  parameter crc_t CRC_POLY   = 16'h1021,
  parameter crc_t CRC_PRESET = 16'hFFFF,
  parameter int   HD_DELAY   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              half_tick,
  input  logic              hd_mode,
  input  logic              wr_on,
  input  logic              rd_on,
  input  logic              crc_on,
  input  logic              crc_out,
  input  logic              drive_en,
  input  logic              byte_wr,
  input  logic [DATA_W-1:0] data_in,
  input  logic [DATA_W-1:0] clock_in,
  output logic              flux,
  output logic              wr_gate
);
  localparam int CELL_W = $clog2(DATA_W);
  localparam logic [CELL_W-1:0] LAST_CELL = CELL_W'(DATA_W - 1);

  half_e             phase_q;
  logic [CELL_W-1:0] cell_q;
  logic              d_hold_q, flux_q;
  logic              cell_step, first_cell;
  logic              raw_d, raw_c, crc_d, enc_c, enc_d;

  assign cell_step  = half_tick && wr_on && (phase_q == HALF_CLK);
  assign first_cell = (cell_q == '0);

  wser_shift #(.W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .hd(hd_mode), .byte_wr(byte_wr),
    .data_in(data_in), .clock_in(clock_in), .take(cell_step),
    .first(first_cell), .raw_d(raw_d), .raw_c(raw_c)
  );

  wser_crc #(.POLY(CRC_POLY), .PRESET(CRC_PRESET)) u_crc (
    .clk(clk), .rst_n(rst_n), .active(wr_on || rd_on), .crc_on(crc_on),
    .crc_out(crc_out), .step(cell_step), .raw_bit(raw_d), .out_bit(crc_d)
  );

  wser_enc #(.DELAY(HD_DELAY)) u_enc (
    .clk(clk), .rst_n(rst_n), .clear(!wr_on), .step(cell_step),
    .hd(hd_mode), .d_in(crc_d), .c_in(raw_c), .enc_c(enc_c), .enc_d(enc_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= HALF_CLK;
      cell_q   <= '0;
      d_hold_q <= 1'b0;
      flux_q   <= 1'b0;
    end else if (!wr_on) begin
      phase_q <= HALF_CLK;
      cell_q  <= '0;
      flux_q  <= 1'b0;
    end else if (half_tick) begin
      if (phase_q == HALF_CLK) begin
        flux_q   <= enc_c;
        d_hold_q <= enc_d;
        phase_q  <= HALF_DAT;
      end else begin
        flux_q  <= d_hold_q;
        phase_q <= HALF_CLK;
        cell_q  <= (cell_q == LAST_CELL) ? '0 : cell_q + 1'b1;
      end
    end else begin
      flux_q <= 1'b0;
    end
  end

  assign flux    = flux_q;
  assign wr_gate = wr_on && drive_en;

  assert_flux_after_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flux_q |-> $past(half_tick && wr_on));
  assert_quiet_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_on |=> !flux_q);
  assert_cell_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_on |=> (cell_q == '0 && phase_q == HALF_CLK));
endmodule

// File: tb/test_wser_top.sv
module test_wser_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic half_tick = 0, hd_mode = 0, wr_on = 0, rd_on = 0, crc_on = 0, crc_out = 0;
  logic drive_en = 0, byte_wr = 0;
  logic [7:0] data_in = 0, clock_in = 0;
  logic flux, wr_gate;
  int checks = 0, fails = 0;
  bit done = 0;

  // bench model state
  logic [7:0]  m_sd = 8'hFF, m_sc = 8'h00;
  logic [15:0] m_crc = 16'hFFFF;
  logic [1:0]  m_hist = 0;
  logic        m_had = 0;

  always #5 clk = ~clk;

  wser_top i_wser_top (
    .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .hd_mode(hd_mode),
    .wr_on(wr_on), .rd_on(rd_on), .crc_on(crc_on), .crc_out(crc_out),
    .drive_en(drive_en), .byte_wr(byte_wr), .data_in(data_in),
    .clock_in(clock_in), .flux(flux), .wr_gate(wr_gate)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic half(output logic f);
    @(negedge clk); half_tick = 1;
    @(negedge clk); half_tick = 0; f = flux;
  endtask

  task automatic put(input logic [7:0] d, input logic [7:0] c);
    @(negedge clk); byte_wr = 1; data_in = d; clock_in = c;
    @(negedge clk); byte_wr = 0;
  endtask

  task automatic restart();
    @(negedge clk); wr_on = 0;
    @(negedge clk); @(negedge clk); wr_on = 1;
    m_hist = 0; m_had = 0;
    if (!rd_on) m_crc = 16'hFFFF;
  endtask

  // model of one cell from the requirements
  task automatic mcell(input bit load, input logic [7:0] d, input logic [7:0] c,
                       output logic mc, output logic md);
    logic rd, rc, db, dd, fb;
    if (load) begin m_sd = d; m_sc = c; end
    rd = hd_mode ? m_sd[0] : m_sd[7];
    rc = hd_mode ? m_sc[0] : m_sc[7];
    m_sd = hd_mode ? {1'b1, m_sd[7:1]} : {m_sd[6:0], 1'b1};
    m_sc = hd_mode ? {1'b0, m_sc[7:1]} : {m_sc[6:0], 1'b0};
    db = rd;
    if (crc_out) begin
      db = m_crc[15]; m_crc = m_crc << 1;
    end else if (crc_on) begin
      fb = m_crc[15] ^ rd; m_crc = m_crc << 1;
      if (fb) m_crc = m_crc ^ 16'h1021;
    end else m_crc = 16'hFFFF;
    if (hd_mode) begin
      dd = m_hist[1]; m_hist = {m_hist[0], db};
      mc = !dd && (rc || !m_had); md = dd; m_had = mc || md;
    end else begin
      mc = rc; md = db;
    end
  endtask

  task automatic run_byte(input bit load, input logic [7:0] d, input logic [7:0] c,
                          output logic [15:0] got, output logic [15:0] exp);
    logic mc, md, f1, f2;
    got = 0; exp = 0;
    for (int i = 0; i < 8; i++) begin
      mcell(load && i == 0, d, c, mc, md);
      exp = {exp[13:0], mc, md};
      half(f1); half(f2);
      got = {got[13:0], f1, f2};
    end
  endtask

  function automatic logic [15:0] dbits(input logic [15:0] a, input logic [15:0] b);
    logic [15:0] r;
    for (int i = 0; i < 8; i++) begin
      r[15-i] = a[14-2*i];
      r[7-i]  = b[14-2*i];
    end
    return r;
  endfunction

  task automatic t_reset();
    chk(flux == 0, "R9 reset flux", {15'd0, flux}, 16'd0);
    chk(wr_gate == 0, "R10 reset gate", {15'd0, wr_gate}, 16'd0);
  endtask

  task automatic t_gate();
    restart();
    @(negedge clk); chk(wr_gate == 0, "R10 gate off", {15'd0, wr_gate}, 16'd0);
    drive_en = 1;
    @(negedge clk); chk(wr_gate == 1, "R10 gate on", {15'd0, wr_gate}, 16'd1);
  endtask

  task automatic t_fm();
    logic [15:0] g, e;
    hd_mode = 0; restart();
    put(8'hA5, 8'hC7); run_byte(1, 8'hA5, 8'hC7, g, e);
    chk(g == 16'hE43B, "R1 fm literal", g, 16'hE43B);
    put(8'h3C, 8'h12); run_byte(1, 8'h3C, 8'h12, g, e);
    chk(g == e, "R1 fm model", g, e);
    run_byte(0, 0, 0, g, e);
    chk(g == 16'h5555, "R3 fill pattern", g, 16'h5555);
  endtask

  task automatic t_pulse();
    logic f, mc, md;
    restart();
    put(8'hFF, 8'hFF);
    mcell(1, 8'hFF, 8'hFF, mc, md);
    half(f);
    chk(f == 1, "R9 pulse high", {15'd0, f}, 16'd1);
    @(negedge clk);
    chk(flux == 0, "R9 pulse one cycle", {15'd0, flux}, 16'd0);
    @(negedge clk); wr_on = 0;
    half(f);
    chk(f == 0, "R8 quiet when off", {15'd0, f}, 16'd0);
  endtask

  task automatic t_mmfm();
    logic [15:0] g, e;
    hd_mode = 1; restart();
    put(8'hFF, 8'h00); run_byte(1, 8'hFF, 8'h00, g, e);
    chk(g == 16'h8555, "R8 history cleared on enable", g, 16'h8555);
    put(8'h3C, 8'h81); run_byte(1, 8'h3C, 8'h81, g, e);
    chk(g == e, "R2 mmfm byte", g, e);
    put(8'h00, 8'hFF); run_byte(1, 8'h00, 8'hFF, g, e);
    chk(g == e, "R2 mmfm clock rule", g, e);
  endtask

  task automatic t_crc();
    logic [15:0] g, e, g2, e2;
    string s = "123456789";
    hd_mode = 0; crc_on = 1; crc_out = 0; restart();
    for (int i = 0; i < 9; i++) begin
      put(s[i], 8'h00); run_byte(1, s[i], 8'h00, g, e);
    end
    crc_out = 1;
    run_byte(0, 0, 0, g, e); run_byte(0, 0, 0, g2, e2);
    chk(dbits(g, g2) == 16'h29B1, "R4 check word", dbits(g, g2), 16'h29B1);
    chk(g == e && g2 == e2, "R5 crc emission", g, e);
    crc_out = 0; crc_on = 0;
    @(negedge clk); m_crc = 16'hFFFF;
    crc_out = 1;
    run_byte(0, 0, 0, g, e); run_byte(0, 0, 0, g2, e2);
    chk(dbits(g, g2) == 16'hFFFF, "R6 held preset", dbits(g, g2), 16'hFFFF);
  endtask

  task automatic t_keep();
    logic [15:0] g, e, g2, e2;
    crc_out = 0; crc_on = 1; rd_on = 0; restart();
    put(8'h31, 8'h00); run_byte(1, 8'h31, 8'h00, g, e);
    rd_on = 1; restart();
    crc_out = 1;
    run_byte(0, 0, 0, g, e); run_byte(0, 0, 0, g2, e2);
    chk(dbits(g, g2) == dbits(e, e2), "R7 crc kept while reading", dbits(g, g2), dbits(e, e2));
    rd_on = 0; restart();
    run_byte(0, 0, 0, g, e); run_byte(0, 0, 0, g2, e2);
    chk(dbits(g, g2) == 16'hFFFF, "R7 preset when idle", dbits(g, g2), 16'hFFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_gate();
    t_fm();
    t_pulse();
    t_mmfm();
    t_crc();
    t_keep();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule